// File: doc/BRIEF.md
# Buffered Time-Set Commit Stage

This block sits between the serial write path of a real-time clock and its running timekeeping counters. Bytes aimed at the seven time registers and the control register are written into a staging buffer while the counters keep advancing on their own. Nothing reaches the counters until chip select rises at the end of the transfer. At that point the buffer goes out as one parallel word with a per-register valid mask and a one-cycle load strobe, so every staged register changes at the same counter edge.

A transfer that ends on a partial byte, or a clock burst that did not deliver all eight bytes, cancels the update and empties the buffer. The load strobe never lands in a cycle that carries the one-second tick. When the two coincide, the tick goes first and the load follows one cycle later. After a load, a busy window of a parameterised cycle count (the post-write access lockout) blocks further byte writes and chip-select events.

Top module: `timeset_commit`

## Requirements
- R1: After reset, `ld_strobe`, `busy` and `ld_mask` are all 0.
- R2: Byte writes only fill the staging buffer. `ld_strobe` stays 0 until a chip-select rise has been accepted.
- R3: A chip-select rise with `xfer_whole`=1 and `xfer_burst`=0, while at least one byte is staged, raises `ld_strobe` in the next cycle. `ld_mask` bit i is set for each register index i written, and register i appears on `ld_data[8*i+7:8*i]` (index 7 is control).
- R4: A chip-select rise with `xfer_whole`=0 commits nothing and discards every staged byte.
- R5: A chip-select rise with `xfer_burst`=1 and `burst_all`=0 commits nothing and discards the buffer.
- R6: A complete clock burst (`xfer_burst`=1, `burst_all`=1, all eight indices written) loads all eight registers with one strobe (`ld_mask`=8'hFF).
- R7: `ld_strobe` is never high in a cycle where `sec_tick` is high. A tick in the due cycle delays the strobe by exactly one cycle.
- R8: `busy` is high while a commit waits and for `LOCK_CYC` cycles after the strobe cycle. Byte writes and chip-select rises seen while `busy` is high have no effect.
- R9: `ld_strobe` lasts one cycle and empties the buffer, so a later chip-select rise with no new writes produces no strobe.
- R10: A chip-select rise with nothing staged produces no strobe and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_we | input | 1 | One complete byte received for a register |
| byte_idx | input | 3 | Register index: 0-6 time registers, 7 control |
| byte_val | input | 8 | Received byte |
| cs_rise | input | 1 | Chip select went inactive (end of transfer) |
| xfer_whole | input | 1 | The transfer ended on a byte boundary |
| xfer_burst | input | 1 | The transfer was a clock burst |
| burst_all | input | 1 | All eight burst bytes were received |
| sec_tick | input | 1 | One-second increment pulse of the counters |
| ld_data | output | 64 | Parallel load word, register i at bits 8i+7..8i |
| ld_mask | output | 8 | Registers to load, valid only with the strobe |
| ld_strobe | output | 1 | Load the counters at this edge |
| busy | output | 1 | Commit pending or access lockout running |

## Verification
A byte write is staged at the edge that samples it. A chip-select rise sets the pending flag at its edge, so the strobe is due in the following cycle, or one cycle later if that cycle carries a tick. The busy flag clears `LOCK_CYC`+1 cycles after the strobe cycle begins. The bench drives inputs on the falling edge, waits a short delay and then samples the combinational strobe. Every check is placed at the exact cycle given by this count. The main sweep covers all 256 subsets of staged registers with a small lockout.

// File: rtl/timeset_commit_pkg.sv
package timeset_commit_pkg;
  typedef enum logic [1:0] {
    CS_NONE   = 2'd0,
    CS_COMMIT = 2'd1,
    CS_DROP   = 2'd2
  } cs_act_e;

  function automatic cs_act_e classify(input logic rise, input logic blocked,
                                       input logic whole, input logic burst,
                                       input logic all_in, input logic any_vld);
    if (!rise || blocked)                        return CS_NONE;
    if (whole && (!burst || all_in) && any_vld)  return CS_COMMIT;
    return CS_DROP;
  endfunction
endpackage

// File: rtl/tsc_stage.sv
module tsc_stage #(
  parameter int NREG = 8,
  parameter int BW   = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_go,
  input  logic               wr_blocked,
  input  logic [AW-1:0]      wr_idx,
  input  logic [BW-1:0]      wr_byte,
  input  logic               clr,
  output logic [NREG*BW-1:0] stage_flat,
  output logic [NREG-1:0]    stage_vld
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic          hit;
    logic [BW-1:0] byte_q, byte_d;
    logic          vld_q, vld_d;

    assign hit = wr_go && (wr_idx == AW'(g));

    always_comb begin
      byte_d = byte_q;
      vld_d  = vld_q;
      if (clr) begin
        vld_d = 1'b0;
      end else if (hit) begin
        byte_d = wr_byte;
        vld_d  = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        byte_q <= byte_d;
        vld_q  <= vld_d;
      end
    end

    assign stage_flat[g*BW +: BW] = byte_q;
    assign stage_vld[g]           = vld_q;
  end

  // R8
  locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_blocked && !clr) |=> $stable(stage_flat) && $stable(stage_vld));
endmodule

// File: rtl/tsc_arbiter.sv
module tsc_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic sec_tick,
  output logic pend,
  output logic strobe
);
  logic pend_q, pend_d;

  assign strobe = pend_q && !sec_tick;

  always_comb begin
    pend_d = pend_q;
    if (strobe)   pend_d = 1'b0;
    else if (req) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  // R7
  tick_defers_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && sec_tick) |=> pend_q);
  // R9
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
endmodule

// File: rtl/tsc_lockout.sv
module tsc_lockout #(
  parameter int LOCK_CYC = 11250,
  localparam int CW      = $clog2(LOCK_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = start || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (start)              cnt_d = CW'(LOCK_CYC);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);

  // R8
  lock_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active);
endmodule

// File: rtl/timeset_commit.sv
module timeset_commit #(
  parameter int NREG     = 8,
  parameter int BW       = 8,
  parameter int LOCK_CYC = 11250,
  localparam int AW      = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               byte_we,
  input  logic [AW-1:0]      byte_idx,
  input  logic [BW-1:0]      byte_val,
  input  logic               cs_rise,
  input  logic               xfer_whole,
  input  logic               xfer_burst,
  input  logic               burst_all,
  input  logic               sec_tick,
  output logic [NREG*BW-1:0] ld_data,
  output logic [NREG-1:0]    ld_mask,
  output logic               ld_strobe,
  output logic               busy
);
  import timeset_commit_pkg::*;

  logic            pend, lock_active;
  logic            wr_go, clr, req;
  logic [NREG-1:0] vld;
  cs_act_e         act;

  assign busy  = pend || lock_active;
  assign wr_go = byte_we && !busy;
  assign act   = classify(cs_rise, busy, xfer_whole, xfer_burst, burst_all, |vld);
  assign req   = (act == CS_COMMIT);
  assign clr   = (act == CS_DROP) || ld_strobe;

  tsc_stage #(.NREG(NREG), .BW(BW)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_go      (wr_go),
    .wr_blocked (byte_we && busy),
    .wr_idx     (byte_idx),
    .wr_byte    (byte_val),
    .clr        (clr),
    .stage_flat (ld_data),
    .stage_vld  (vld)
  );

  tsc_arbiter u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .sec_tick (sec_tick),
    .pend     (pend),
    .strobe   (ld_strobe)
  );

  tsc_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (ld_strobe),
    .active (lock_active)
  );

  assign ld_mask = ld_strobe ? vld : '0;

  // R7
  no_tick_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_strobe && sec_tick));
  // R4
  partial_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !busy && !xfer_whole) |=> (!pend && !ld_strobe));
  // R10
  empty_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !busy && (vld == '0)) |=> !busy);
  // R3
  strobe_has_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_strobe |-> (ld_mask != '0));
endmodule

// File: tb/test_timeset_commit.sv
module test_timeset_commit;
  localparam int L = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_we, cs_rise, xfer_whole, xfer_burst, burst_all, sec_tick;
  logic [2:0]  byte_idx;
  logic [7:0]  byte_val;
  logic [63:0] ld_data;
  logic [7:0]  ld_mask;
  logic        ld_strobe, busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  timeset_commit #(.LOCK_CYC(L)) i_timeset_commit (
    .clk(clk), .rst_n(rst_n), .byte_we(byte_we), .byte_idx(byte_idx),
    .byte_val(byte_val), .cs_rise(cs_rise), .xfer_whole(xfer_whole),
    .xfer_burst(xfer_burst), .burst_all(burst_all), .sec_tick(sec_tick),
    .ld_data(ld_data), .ld_mask(ld_mask), .ld_strobe(ld_strobe), .busy(busy)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [2:0] a, input logic [7:0] d,
                     input logic cs, input logic wh, input logic bu,
                     input logic al, input logic tk);
    @(negedge clk);
    byte_we = we; byte_idx = a; byte_val = d; cs_rise = cs;
    xfer_whole = wh; xfer_burst = bu; burst_all = al; sec_tick = tk;
    #1;
  endtask

  task automatic idle();
    cyc(1'b0, 3'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  function automatic logic [7:0] pat(input int i, input int m);
    return 8'((i * 29 + m * 7 + 3) & 255);
  endfunction

  task automatic wait_lock(input string req);
    for (int k = 1; k <= L; k++) begin
      idle();
      if (k == 1 || k == L) chk(req, {63'd0, busy}, 64'd1);
    end
    idle();
    chk(req, {63'd0, busy}, 64'd0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    byte_we = 0; byte_idx = 0; byte_val = 0; cs_rise = 0;
    xfer_whole = 0; xfer_burst = 0; burst_all = 0; sec_tick = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk("R1 strobe", {63'd0, ld_strobe}, 64'd0);
    chk("R1 busy", {63'd0, busy}, 64'd0);
    chk("R1 mask", {56'd0, ld_mask}, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // R3 R10 R9: every subset of staged registers
    for (int m = 0; m < 256; m++) begin
      for (int i = 0; i < 8; i++)
        if (m[i]) begin
          cyc(1'b1, 3'(i), pat(i, m), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
          chk("R2 no early strobe", {63'd0, ld_strobe}, 64'd0);
        end
      cyc(1'b0, 3'd0, 8'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      idle();
      if (m == 0) begin
        chk("R10 no strobe", {63'd0, ld_strobe}, 64'd0);
        chk("R10 busy low", {63'd0, busy}, 64'd0);
      end else begin
        chk("R3 strobe", {63'd0, ld_strobe}, 64'd1);
        chk("R3 mask", {56'd0, ld_mask}, 64'(m));
        for (int i = 0; i < 8; i++)
          if (m[i]) chk("R3 data", {56'd0, ld_data[i*8 +: 8]}, {56'd0, pat(i, m)});
        wait_lock("R8 lock window");
        cyc(1'b0, 3'd0, 8'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        idle();
        chk("R9 buffer emptied", {63'd0, ld_strobe}, 64'd0);
      end
    end

    // R4 partial transfer discards
    cyc(1'b1, 3'd5, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 3'd0, 8'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    idle();
    chk("R4 no strobe", {63'd0, ld_strobe}, 64'd0);
    cyc(1'b1, 3'd1, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 3'd0, 8'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    idle();
    chk("R4 only new byte", {56'd0, ld_mask}, 64'h02);
    chk("R4 data", {56'd0, ld_data[15:8]}, 64'h3C);
    wait_lock("R8 lock window");

    // R5 short burst discards
    for (int i = 0; i < 8; i++)
      cyc(1'b1, 3'(i), 8'(8'h10 + i), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 3'd0, 8'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    idle();
    chk("R5 no strobe", {63'd0, ld_strobe}, 64'd0);
    cyc(1'b0, 3'd0, 8'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    idle();
    chk("R5 buffer discarded", {63'd0, ld_strobe}, 64'd0);

    // R6 full burst
    for (int i = 0; i < 8; i++)
      cyc(1'b1, 3'(i), 8'(8'h40 + i), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 3'd0, 8'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    idle();
    chk("R6 strobe", {63'd0, ld_strobe}, 64'd1);
    chk("R6 mask", {56'd0, ld_mask}, 64'hFF);
    chk("R6 data", ld_data, 64'h4746454443424140);
    wait_lock("R8 lock window");

    // R7 tick collides with due commit
    cyc(1'b1, 3'd2, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 3'd0, 8'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 3'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R7 held off by tick", {63'd0, ld_strobe}, 64'd0);
    chk("R7 busy while waiting", {63'd0, busy}, 64'd1);
    idle();
    chk("R7 strobe one cycle later", {63'd0, ld_strobe}, 64'd1);
    chk("R7 mask", {56'd0, ld_mask}, 64'h04);
    wait_lock("R8 lock window");

    // R8 writes and cs during lockout ignored
    cyc(1'b1, 3'd0, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 3'd0, 8'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    idle();
    chk("R8 strobe", {63'd0, ld_strobe}, 64'd1);
    cyc(1'b1, 3'd3, 8'h99, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 3'd0, 8'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    idle();
    chk("R8 cs ignored while busy", {63'd0, ld_strobe}, 64'd0);
    repeat (L) idle();
    chk("R8 busy clear", {63'd0, busy}, 64'd0);
    cyc(1'b0, 3'd0, 8'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    idle();
    chk("R8 write ignored while busy", {63'd0, ld_strobe}, 64'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule